// File: doc/BRIEF.md
# Programmable Repeating Line-Test Code Inserter

This block sits in a serial transmit path and, when enabled, replaces the outgoing bit stream with a short repeating test code. Software writes the code into a pattern field and chooses a code length of 4, 5, 6 or 7 bits. Codes with a period of 2 or 3 bits are made by writing the short code twice into the 4-bit or 6-bit length. A constant one or zero stream comes from a pattern of all ones or all zeros. Register decode is outside the block, so every setting arrives as a plain input.

A bit-rate enable marks each bit slot. A second input flags the slots that carry the framing bit. By default the code leaves those slots alone: the incoming bit is passed on and the code position does not move, so the code runs on without a break on either side of the framing bit. In unframed mode the code is written over every slot, framing slots included. While the enable bit is low, the block passes data through with one bit slot of delay.

Top module: `ibcode_gen`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `tx_data_out` is 0 and the code position is 0.
- R2: When `cfg_start` is 0, a cycle with `bit_en` high loads `tx_data_in` into `tx_data_out`, so the output follows the input one bit slot later.
- R3: `tx_data_out` and the code position change only in cycles with `bit_en` high. Slots without the enable have no effect on the output or on where the code resumes.
- R4: `cfg_len_sel` values 0, 1, 2 and 3 select code lengths L of 4, 5, 6 and 7. The code is `cfg_pattern[L-1:0]` and is sent most significant bit first, so code bit k after start is `cfg_pattern[L-1-(k mod L)]`.
- R5: Pattern bits at positions L and above have no effect on the output.
- R6: With `cfg_unframed` at 0, a slot with `tx_fbit_in` high passes `tx_data_in` through, and the code position holds, so the code continues without a break after the framing bit.
- R7: With `cfg_unframed` at 1, framing slots carry the next code bit, and the code position advances as on any other slot.
- R8: Clearing `cfg_start` gives pass-through from the next bit slot and resets the code position. A later start begins again at `cfg_pattern[L-1]`.
- R9: A 2-bit code written twice in 4-bit length repeats with period 2. A 3-bit code written twice in 6-bit length repeats with period 3. An all-ones pattern gives a constant 1 output.
- R10: If the length is reduced while the code position lies beyond the new last position, the next code bit is `cfg_pattern[L-1]` of the new length, and counting continues from there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit-slot enable, one cycle per transmitted bit |
| cfg_pattern | input | PAT_W (7) | Code pattern; the low L bits are used |
| cfg_len_sel | input | SEL_W (2) | Code length select: L = MIN_LEN + value |
| cfg_start | input | 1 | 1 = insert code, 0 = pass through |
| cfg_unframed | input | 1 | 1 = the code also overwrites framing slots |
| tx_data_in | input | 1 | Serial transmit data in |
| tx_fbit_in | input | 1 | High on the framing-bit slot |
| tx_data_out | output | 1 | Serial transmit data out, registered |

## Verification
The bench sweeps all 128 pattern values at every length, in both framed and unframed mode. Framing slots fall at positions that do not line up with the code period. A design that advanced the code position on a spared framing slot would shift the rest of the code by one bit. A design that used pattern bits above L would show wrong bits whenever those upper bits differ. Separate directed runs cover a stop followed by a restart, which must begin again at the top bit, and a length cut while the position is beyond the new end, which a bare wrap-on-equality counter would run past. Runs with the bit enable held low check that idle cycles neither change the output nor move the code position.

// File: rtl/ibcode_pkg.sv
package ibcode_pkg;

  // Code length for a given length-select value
  function automatic int unsigned code_len(input int unsigned sel,
                                           input int unsigned min_len);
    return min_len + sel;
  endfunction

endpackage

// File: rtl/ibcode_phase.sv
// Code position counter: wraps at the selected last position, holds on spared slots
module ibcode_phase #(
  parameter int PH_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bit_en,
  input  logic            run,
  input  logic            hold,
  input  logic [PH_W-1:0] last,
  output logic [PH_W-1:0] phase,
  output logic [PH_W-1:0] eff
);

  // A position past the end (after the length is cut) is treated as position 0
  always_comb begin
    eff = (phase > last) ? '0 : phase;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
    end else if (bit_en) begin
      if (!run) begin
        phase <= '0;
      end else if (!hold) begin
        phase <= (eff == last) ? '0 : eff + 1'b1;
      end
    end
  end

endmodule

// File: rtl/ibcode_pick.sv
// Selects the current code bit, MSB of the active field first
module ibcode_pick #(
  parameter int PAT_W = 7,
  parameter int PH_W  = 3
) (
  input  logic [PAT_W-1:0] pattern,
  input  logic [PH_W-1:0]  last,
  input  logic [PH_W-1:0]  eff,
  output logic             code_bit
);

  logic [PH_W-1:0] idx;

  always_comb begin
    idx      = last - eff;
    code_bit = 1'b0;
    for (int i = 0; i < PAT_W; i++) begin
      if (idx == i[PH_W-1:0]) code_bit = pattern[i];
    end
  end

endmodule

// File: rtl/ibcode_gen.sv
module ibcode_gen #(
  parameter int PAT_W   = 7,
  parameter int SEL_W   = 2,
  parameter int MIN_LEN = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_en,
  input  logic [PAT_W-1:0] cfg_pattern,
  input  logic [SEL_W-1:0] cfg_len_sel,
  input  logic             cfg_start,
  input  logic             cfg_unframed,
  input  logic             tx_data_in,
  input  logic             tx_fbit_in,
  output logic             tx_data_out
);
  import ibcode_pkg::*;

  localparam int PH_W    = (PAT_W > 1) ? $clog2(PAT_W) : 1;
  localparam int MAX_LEN = int'(code_len((1 << SEL_W) - 1, MIN_LEN));
  localparam logic [PH_W-1:0] BASE_LAST = PH_W'(MIN_LEN - 1);

  initial begin
    if (MAX_LEN > PAT_W) $error("length select exceeds pattern width");
  end

  logic [PH_W-1:0] last;
  logic [PH_W-1:0] phase_q;
  logic [PH_W-1:0] phase_eff;
  logic            hold;
  logic            code_bit;

  assign last = BASE_LAST + PH_W'(cfg_len_sel);
  assign hold = tx_fbit_in & ~cfg_unframed;

  ibcode_phase #(.PH_W(PH_W)) phase_i (
    .clk   (clk),
    .rst   (rst),
    .bit_en(bit_en),
    .run   (cfg_start),
    .hold  (hold),
    .last  (last),
    .phase (phase_q),
    .eff   (phase_eff)
  );

  ibcode_pick #(.PAT_W(PAT_W), .PH_W(PH_W)) pick_i (
    .pattern (cfg_pattern),
    .last    (last),
    .eff     (phase_eff),
    .code_bit(code_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_data_out <= 1'b0;
    end else if (bit_en) begin
      tx_data_out <= (!cfg_start || hold) ? tx_data_in : code_bit;
    end
  end

endmodule

// File: rtl/ibcode_chk.sv
module ibcode_chk #(
  parameter int PH_W  = 3,
  parameter int PAT_W = 7
) (
  input logic            clk,
  input logic            rst,
  input logic            bit_en,
  input logic            cfg_start,
  input logic            cfg_unframed,
  input logic            tx_data_in,
  input logic            tx_fbit_in,
  input logic            tx_data_out,
  input logic [PH_W-1:0] phase
);

  AST_RESET_OUT: assert property (@(posedge clk) rst |=> (tx_data_out == 1'b0 && phase == '0)); // R1
  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (rst)
    (bit_en && !cfg_start) |=> tx_data_out == $past(tx_data_in)); // R2
  AST_NO_EN_OUT: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(tx_data_out)); // R3
  AST_NO_EN_PHASE: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(phase)); // R3
  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (rst)
    phase <= PH_W'(PAT_W - 1)); // R4
  AST_FBIT_PASS: assert property (@(posedge clk) disable iff (rst)
    (bit_en && cfg_start && tx_fbit_in && !cfg_unframed) |=> tx_data_out == $past(tx_data_in)); // R6
  AST_FBIT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (bit_en && cfg_start && tx_fbit_in && !cfg_unframed) |=> $stable(phase)); // R6
  AST_STOP_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (bit_en && !cfg_start) |=> phase == '0); // R8

endmodule

bind ibcode_gen ibcode_chk #(.PH_W(PH_W), .PAT_W(PAT_W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .bit_en      (bit_en),
  .cfg_start   (cfg_start),
  .cfg_unframed(cfg_unframed),
  .tx_data_in  (tx_data_in),
  .tx_fbit_in  (tx_fbit_in),
  .tx_data_out (tx_data_out),
  .phase       (phase_q)
);

// File: tb/ibcode_gen_tb.sv
module ibcode_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PAT_W = 7;
  localparam int SEL_W = 2;
  localparam int MIN_LEN = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_en = 1'b0;
  logic [PAT_W-1:0] cfg_pattern = '0;
  logic [SEL_W-1:0] cfg_len_sel = '0;
  logic cfg_start = 1'b0;
  logic cfg_unframed = 1'b0;
  logic tx_data_in = 1'b0;
  logic tx_fbit_in = 1'b0;
  logic tx_data_out;

  int checks = 0;
  int fails = 0;
  int k = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ibcode_gen #(.PAT_W(PAT_W), .SEL_W(SEL_W), .MIN_LEN(MIN_LEN)) dut_i (
    .clk(clk), .rst(rst), .bit_en(bit_en), .cfg_pattern(cfg_pattern),
    .cfg_len_sel(cfg_len_sel), .cfg_start(cfg_start), .cfg_unframed(cfg_unframed),
    .tx_data_in(tx_data_in), .tx_fbit_in(tx_fbit_in), .tx_data_out(tx_data_out)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: tx_data_out=%0b expected=%0b (pat=%b sel=%0d k=%0d)",
               req, act, exp, cfg_pattern, cfg_len_sel, k);
    end
  endtask

  // One bit slot: drive at negedge, sample at the following negedge
  task automatic slot(input logic en, input logic din, input logic fb);
    bit_en = en; tx_data_in = din; tx_fbit_in = fb;
    @(negedge clk);
  endtask

  function automatic logic code_at(input logic [PAT_W-1:0] p, input int len, input int idx);
    return p[len - 1 - (idx % len)];
  endfunction

  // Run n slots of code; framing every 5th slot (offset 3)
  task automatic run_code(input int n, input string req);
    int len;
    len = MIN_LEN + int'(cfg_len_sel);
    for (int i = 0; i < n; i++) begin
      logic fb, din, exp;
      fb  = ((i % 5) == 3);
      din = logic'(((i * 7) + int'(cfg_pattern)) & 1);
      slot(1'b1, din, fb);
      if (fb && !cfg_unframed) begin
        exp = din;
      end else begin
        exp = code_at(cfg_pattern, len, k);
        k++;
      end
      check(req, tx_data_out, exp);
    end
  endtask

  task automatic stop_slot(input string req);
    slot(1'b1, 1'b1, 1'b0);
    check(req, tx_data_out, 1'b1);
    slot(1'b1, 1'b0, 1'b0);
    check(req, tx_data_out, 1'b0);
    k = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    check("R1", tx_data_out, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", tx_data_out, 1'b0);

    // R2: idle pass-through
    cfg_start = 1'b0;
    for (int i = 0; i < 6; i++) begin
      slot(1'b1, logic'((i >> 1) & 1), logic'(i & 1));
      check("R2", tx_data_out, logic'((i >> 1) & 1));
    end

    // R4 R5 R6 R7: full sweep of pattern, length and framing mode
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        for (int p = 0; p < (1 << PAT_W); p++) begin
          cfg_start = 1'b0;
          cfg_unframed = logic'(m);
          cfg_len_sel = SEL_W'(s);
          cfg_pattern = PAT_W'(p);
          stop_slot("R8");
          cfg_start = 1'b1;
          run_code(2 * (MIN_LEN + s) + 4, m == 0 ? "R6_R4_R5" : "R7_R4_R5");
        end
      end
    end

    // R3: idle cycles change nothing, code resumes in place
    cfg_start = 1'b0; cfg_unframed = 1'b1; cfg_len_sel = 2'd3; cfg_pattern = 7'b1011001;
    stop_slot("R8");
    cfg_start = 1'b1;
    run_code(3, "R4");
    for (int i = 0; i < 5; i++) begin
      slot(1'b0, logic'(i & 1), 1'b0);
      check("R3", tx_data_out, code_at(cfg_pattern, 7, k - 1));
    end
    run_code(6, "R3");

    // R8: stop mid-code, restart from the top bit
    cfg_start = 1'b0;
    stop_slot("R8");
    cfg_start = 1'b1;
    slot(1'b1, 1'b0, 1'b0);
    check("R8", tx_data_out, cfg_pattern[6]);
    k = 1;
    run_code(4, "R8");

    // R9: short periods and constant output
    cfg_start = 1'b0; cfg_unframed = 1'b1;
    cfg_len_sel = 2'd0; cfg_pattern = 7'b0001010;
    stop_slot("R8");
    cfg_start = 1'b1;
    for (int i = 0; i < 8; i++) begin
      slot(1'b1, 1'b0, 1'b0);
      check("R9", tx_data_out, logic'((i & 1) == 0));
    end
    cfg_start = 1'b0; cfg_len_sel = 2'd2; cfg_pattern = 7'b0110110;
    stop_slot("R8");
    cfg_start = 1'b1;
    for (int i = 0; i < 9; i++) begin
      slot(1'b1, 1'b0, 1'b0);
      check("R9", tx_data_out, logic'((i % 3) != 2));
    end
    cfg_start = 1'b0; cfg_len_sel = 2'd3; cfg_pattern = 7'h7F;
    stop_slot("R8");
    cfg_start = 1'b1;
    for (int i = 0; i < 9; i++) begin
      slot(1'b1, 1'b0, (i % 4) == 1);
      check("R9", tx_data_out, 1'b1);
    end

    // R10: cut length while position is past the new end
    cfg_start = 1'b0; cfg_len_sel = 2'd3; cfg_pattern = 7'b0100110;
    stop_slot("R8");
    cfg_start = 1'b1;
    for (int i = 0; i < 6; i++) begin
      slot(1'b1, 1'b0, 1'b0);
      check("R4", tx_data_out, code_at(cfg_pattern, 7, i));
    end
    cfg_len_sel = 2'd0;
    for (int i = 0; i < 8; i++) begin
      slot(1'b1, 1'b0, 1'b0);
      check("R10", tx_data_out, code_at(cfg_pattern, 4, i));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule